// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Buffer

This block is the bus side of a 2048-byte non-volatile store. It listens on a two-wire serial bus and acts as a slave. The bus clock and data lines are oversampled by the system clock. START and STOP are recognised as data edges while the bus clock is high, and data bits are taken on the rising edge of the bus clock. The block acknowledges its device address and accepts writes of a single byte or of a page. It serves reads of three kinds: from the current address, from an address set by a preceding dummy write, and sequential reads that run on through the array. The array is modelled as a synchronous register array. Internal programming is a counted window of system-clock ticks.

Written bytes collect in a 16-byte page buffer. They reach the array only when a STOP ends the write sequence. The STOP also starts a self-timed busy window, and during that window the slave ignores the bus and does not acknowledge its address. The buffered bytes drain into the array one per tick at the start of the window. Writes are suppressed when the write-protect input is high or when the supply-low flag is active at the STOP. In that case the data bytes are still acknowledged, but nothing is programmed and no busy window follows.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the slave does not pull the data line low and is not busy, so its device address is acknowledged at once.
- R2: A device byte whose upper four bits are 1010 is acknowledged by pulling data low during the ninth clock. Any other upper nibble gets no acknowledge, and the slave then waits for the next START.
- R3: Device byte bits 3..1 form address bits 10..8. The next byte forms address bits 7..0. A byte write followed by a random read at the same 11-bit address returns the written byte, and addresses that differ only in bits 10..8 hold separate bytes.
- R4: In a page write, each data byte goes to the current address and then only address bits 3..0 increment, wrapping within the 16-byte page. Bytes beyond the sixteenth overwrite the start of the same page.
- R5: After a STOP that ends a write carrying at least one data byte, the device address is not acknowledged for WR_TICKS clock cycles. After that it is acknowledged again.
- R6: While the write-protect input is high at the STOP, data bytes are still acknowledged, the array keeps its contents, and no busy window starts.
- R7: While the supply-low flag is high at the STOP, the array keeps its contents and no busy window starts.
- R8: A sequential read increments the full 11-bit address after each byte and rolls over from 0x7FF to 0x000. The read ends when the master answers a byte with no acknowledge.
- R9: A current-address read returns the byte at one past the last address that was read.
- R10: Data is committed only by a STOP. A repeated START after data bytes discards them, with no programming and no busy window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wired line |
| wp_i | input | 1 | Write protect; high blocks programming |
| supply_low_i | input | 1 | Supply-low or reset flag; high blocks programming |
| sda_oe_o | output | 1 | High pulls the open-drain data line low |

## Verification
The hardest situation to reach is the page-pointer wrap combined with the deferred commit. The bytes that overwrite the head of a page only land in the array after the STOP, during the drain at the start of the busy window. The bench therefore sends eighteen bytes in one page write, waits out the busy window, and reads the whole page back sequentially. A repeated START is placed between data bytes and a STOP to show that the buffered byte never reaches the array. The busy window is probed by addressing the slave immediately after the STOP and again after the window has run out. The same immediate probe after protected and supply-low writes shows that no window started.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_MACK
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b);
        return b[7:4] == DEV_CODE;
    endfunction

endpackage

// File: rtl/eeprom_bus_cond.sv
module eeprom_bus_cond
    import eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q, scl_p, sda_q, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            scl_p <= 1'b1;
            sda_q <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_i;
            scl_p <= scl_q;
            sda_q <= sda_i;
            sda_p <= sda_q;
        end
    end

    always_comb begin
        ev_o.start = scl_q & scl_p & sda_p & ~sda_q;
        ev_o.stop  = scl_q & scl_p & ~sda_p & sda_q;
        ev_o.rise  = scl_q & ~scl_p;
        ev_o.fall  = ~scl_q & scl_p;
        ev_o.sda   = sda_q;
    end
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [PAGE_W-1:0] widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PAGE_W-1:0] ridx_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            valid_q <= '0;
        end else if (we_i) begin
            valid_q[widx_i] <= 1'b1;
            slot_q[widx_i]  <= wdata_i;
        end
    end

    assign rdata_o  = slot_q[ridx_i];
    assign rvalid_o = valid_q[ridx_i];
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter int TICKS = 500000,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             busy_o,
    output logic             drain_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(TICKS - 1);
    localparam logic [CNT_W-1:0] DRAIN_N = CNT_W'(1 << IDX_W);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i && !run_q) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy_o  = run_q;
    assign drain_o = run_q && (cnt_q < DRAIN_N);
    assign idx_o   = cnt_q[IDX_W-1:0];
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int PAGE_W   = 4,
    parameter int WR_TICKS = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    input  logic supply_low_i,
    output logic sda_oe_o
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int BLK_W      = ADDR_W - 8;
    localparam int PG_W       = ADDR_W - PAGE_W;

    generate
        if (BLK_W < 1 || BLK_W > 3) begin : g_bad_addr
            $error("ADDR_W must lie between 9 and 11");
        end
        if (WR_TICKS < PAGE_BYTES) begin : g_bad_ticks
            $error("WR_TICKS must cover the page drain");
        end
    endgenerate

    bus_ev_t    ev;
    bus_state_e state_q;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q, tx_q, rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PG_W-1:0]   wpage_q;
    logic rw_q, nack_q, pending_q, sda_oe_q;

    logic busy, drain, buf_valid, buf_we, buf_clr, commit, mem_we, byte_done;
    logic [PAGE_W-1:0] drain_idx;
    logic [7:0] buf_data;
    logic [7:0] mem_q [DEPTH];

    eeprom_bus_cond u_cond (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
    );

    assign byte_done = ev.fall && (bitcnt_q == 4'd8);
    assign buf_we    = !busy && !ev.stop && !ev.start
                       && (state_q == ST_WDATA) && byte_done;
    assign buf_clr   = ev.start && !busy;
    assign commit    = ev.stop && !busy && pending_q && !wp_i && !supply_low_i;

    eeprom_page_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) u_buf (
        .clk(clk), .rst(rst), .clr_i(buf_clr), .we_i(buf_we),
        .widx_i(addr_q[PAGE_W-1:0]), .wdata_i(shreg_q),
        .ridx_i(drain_idx), .rdata_o(buf_data), .rvalid_o(buf_valid)
    );

    eeprom_busy_timer #(.TICKS(WR_TICKS), .IDX_W(PAGE_W)) u_timer (
        .clk(clk), .rst(rst), .start_i(commit),
        .busy_o(busy), .drain_o(drain), .idx_o(drain_idx)
    );

    assign mem_we = drain && buf_valid;

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[{wpage_q, drain_idx}] <= buf_data;
        rd_q <= mem_q[addr_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wpage_q <= '0;
        end else if (commit) begin
            wpage_q <= addr_q[ADDR_W-1:PAGE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            tx_q      <= '0;
            addr_q    <= '0;
            blk_q     <= '0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b1;
            pending_q <= 1'b0;
            sda_oe_q  <= 1'b0;
        end else if (busy) begin
            state_q   <= ST_IDLE;
            sda_oe_q  <= 1'b0;
            pending_q <= 1'b0;
        end else if (ev.stop) begin
            state_q   <= ST_IDLE;
            sda_oe_q  <= 1'b0;
            pending_q <= 1'b0;
        end else if (ev.start) begin
            state_q   <= ST_DEV;
            bitcnt_q  <= '0;
            sda_oe_q  <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            case (state_q)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (ev.rise && bitcnt_q != 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], ev.sda};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (byte_done) begin
                        bitcnt_q <= '0;
                        if (state_q == ST_DEV) begin
                            if (dev_match(shreg_q)) begin
                                rw_q     <= shreg_q[0];
                                blk_q    <= shreg_q[BLK_W:1];
                                sda_oe_q <= 1'b1;
                                state_q  <= ST_DEV_ACK;
                            end else begin
                                state_q  <= ST_IDLE;
                            end
                        end else if (state_q == ST_WADDR) begin
                            addr_q   <= {blk_q, shreg_q};
                            sda_oe_q <= 1'b1;
                            state_q  <= ST_WADDR_ACK;
                        end else begin
                            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                            pending_q <= 1'b1;
                            sda_oe_q  <= 1'b1;
                            state_q   <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev.fall) begin
                        bitcnt_q <= '0;
                        if (rw_q) begin
                            tx_q     <= rd_q;
                            addr_q   <= addr_q + 1'b1;
                            sda_oe_q <= ~rd_q[7];
                            state_q  <= ST_TX;
                        end else begin
                            sda_oe_q <= 1'b0;
                            state_q  <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (ev.fall) begin
                        sda_oe_q <= 1'b0;
                        state_q  <= ST_WDATA;
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt_q == 4'd7) begin
                            sda_oe_q <= 1'b0;
                            state_q  <= ST_MACK;
                        end else begin
                            tx_q     <= {tx_q[6:0], 1'b0};
                            sda_oe_q <= ~tx_q[6];
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        nack_q <= ev.sda;
                    end else if (ev.fall) begin
                        if (nack_q) begin
                            state_q <= ST_IDLE;
                        end else begin
                            tx_q     <= rd_q;
                            addr_q   <= addr_q + 1'b1;
                            sda_oe_q <= ~rd_q[7];
                            bitcnt_q <= '0;
                            state_q  <= ST_TX;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe_o = sda_oe_q;
endmodule

module eeprom_i2c_checker (
    input logic clk,
    input logic rst,
    input logic wp_i,
    input logic supply_low_i,
    input logic sda_oe_o,
    input logic busy,
    input logic fall_i,
    input logic start_i,
    input logic stop_i
);
    // R1: reset leaves the line released and the slave idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && !busy));

    // R2: the slave moves the data line only after a clock fall or a bus condition
    a_r2_sda_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> $past(fall_i || start_i || stop_i));

    // R5: during the busy window nothing is driven onto the bus
    a_r5_silent_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe_o);

    // R6: a busy window never opens while write protect was high
    a_r6_wp_no_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!wp_i));

    // R7: a busy window never opens while the supply was low
    a_r7_low_no_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!supply_low_i));
endmodule

bind eeprom_i2c_slave eeprom_i2c_checker u_chk (
    .clk(clk), .rst(rst), .wp_i(wp_i), .supply_low_i(supply_low_i),
    .sda_oe_o(sda_oe_o), .busy(busy),
    .fall_i(ev.fall), .start_i(ev.start), .stop_i(ev.stop)
);

// File: tb/tb_eeprom_i2c_slave.sv
module tb_eeprom_i2c_slave;
    localparam int TICKS = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic low = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] rbuf [32];

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    eeprom_i2c_slave #(.ADDR_W(11), .PAGE_W(4), .WR_TICKS(TICKS)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .wp_i(wp), .supply_low_i(low), .sda_oe_o(sda_oe)
    );

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; gap(4);
        scl_m = 1'b1; gap(4);
        sda_m = 1'b0; gap(4);
        scl_m = 1'b0; gap(4);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; gap(4);
        scl_m = 1'b1; gap(4);
        sda_m = 1'b1; gap(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; gap(4);
            scl_m = 1'b1; gap(4);
            scl_m = 1'b0; gap(4);
        end
        sda_m = 1'b1; gap(4);
        scl_m = 1'b1; gap(2);
        ack = ~sda_line; gap(2);
        scl_m = 1'b0; gap(4);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            gap(4);
            scl_m = 1'b1; gap(2);
            b[i] = sda_line; gap(2);
            scl_m = 1'b0;
        end
        gap(2);
        sda_m = ~ack; gap(2);
        scl_m = 1'b1; gap(4);
        scl_m = 1'b0; gap(2);
        sda_m = 1'b1; gap(2);
    endtask

    task automatic write_seq(input logic [10:0] a, input logic [7:0] first,
                             input int n, output logic all_ack);
        logic ack;
        all_ack = 1'b1;
        i2c_start;
        send_byte({4'hA, a[10:8], 1'b0}, ack); all_ack &= ack;
        send_byte(a[7:0], ack); all_ack &= ack;
        for (int i = 0; i < n; i++) begin
            send_byte(first + 8'(i), ack); all_ack &= ack;
        end
        i2c_stop;
    endtask

    task automatic read_rand(input logic [10:0] a, input int n);
        logic ack;
        i2c_start;
        send_byte({4'hA, a[10:8], 1'b0}, ack);
        send_byte(a[7:0], ack);
        i2c_start;
        send_byte({4'hA, a[10:8], 1'b1}, ack);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        i2c_stop;
    endtask

    task automatic poll(output logic ack);
        i2c_start;
        send_byte(8'hA0, ack);
        i2c_stop;
    endtask

    task automatic wait_busy;
        gap(TICKS + 20);
    endtask

    task automatic t_reset;
        logic ack;
        chk("R1 line released after reset", {7'd0, sda_oe}, 8'd0);
        poll(ack);
        chk("R1 address acked after reset", {7'd0, ack}, 8'd1);
    endtask

    task automatic t_match;
        logic ack;
        i2c_start; send_byte(8'hA0, ack); i2c_stop;
        chk("R2 code 1010 acked", {7'd0, ack}, 8'd1);
        i2c_start; send_byte(8'h60, ack); i2c_stop;
        chk("R2 code 0110 not acked", {7'd0, ack}, 8'd0);
        i2c_start; send_byte(8'hB2, ack); i2c_stop;
        chk("R2 code 1011 not acked", {7'd0, ack}, 8'd0);
    endtask

    task automatic t_byte_write;
        logic ok;
        write_seq(11'h5A3, 8'h3C, 1, ok);
        chk("R3 write bytes acked", {7'd0, ok}, 8'd1);
        wait_busy;
        write_seq(11'h0A3, 8'hC3, 1, ok);
        wait_busy;
        read_rand(11'h5A3, 1);
        chk("R3 read 0x5A3", rbuf[0], 8'h3C);
        read_rand(11'h0A3, 1);
        chk("R3 read 0x0A3", rbuf[0], 8'hC3);
    endtask

    task automatic t_busy;
        logic ok, ack;
        write_seq(11'h010, 8'h11, 1, ok);
        poll(ack);
        chk("R5 not acked while busy", {7'd0, ack}, 8'd0);
        wait_busy;
        poll(ack);
        chk("R5 acked after busy window", {7'd0, ack}, 8'd1);
    endtask

    task automatic t_page;
        logic ok;
        write_seq(11'h120, 8'h40, 18, ok);
        chk("R4 page bytes acked", {7'd0, ok}, 8'd1);
        wait_busy;
        read_rand(11'h120, 16);
        chk("R4 wrapped byte 16", rbuf[0], 8'h50);
        chk("R4 wrapped byte 17", rbuf[1], 8'h51);
        for (int i = 2; i < 16; i++) chk("R4 page body", rbuf[i], 8'h40 + 8'(i));
    endtask

    task automatic t_wp;
        logic ok, ack;
        wp = 1'b1;
        write_seq(11'h120, 8'hEE, 1, ok);
        chk("R6 data acked under protect", {7'd0, ok}, 8'd1);
        poll(ack);
        chk("R6 no busy window", {7'd0, ack}, 8'd1);
        wp = 1'b0;
        read_rand(11'h120, 1);
        chk("R6 array unchanged", rbuf[0], 8'h50);
    endtask

    task automatic t_low;
        logic ok, ack;
        low = 1'b1;
        write_seq(11'h121, 8'hDD, 1, ok);
        poll(ack);
        chk("R7 no busy window", {7'd0, ack}, 8'd1);
        low = 1'b0;
        read_rand(11'h121, 1);
        chk("R7 array unchanged", rbuf[0], 8'h51);
    endtask

    task automatic t_restart;
        logic ack;
        i2c_start;
        send_byte(8'hA2, ack);
        send_byte(8'h22, ack);
        send_byte(8'h99, ack);
        i2c_start;
        send_byte(8'hA0, ack);
        i2c_stop;
        poll(ack);
        chk("R10 restart leaves no busy window", {7'd0, ack}, 8'd1);
        read_rand(11'h122, 1);
        chk("R10 discarded byte not stored", rbuf[0], 8'h42);
    endtask

    task automatic t_roll_and_current;
        logic ok, ack;
        logic [7:0] b;
        write_seq(11'h7FF, 8'hAB, 1, ok);
        wait_busy;
        write_seq(11'h000, 8'hCD, 1, ok);
        wait_busy;
        write_seq(11'h001, 8'h77, 1, ok);
        wait_busy;
        read_rand(11'h7FF, 2);
        chk("R8 read at 0x7FF", rbuf[0], 8'hAB);
        chk("R8 rollover to 0x000", rbuf[1], 8'hCD);
        i2c_start;
        send_byte(8'hA1, ack);
        recv_byte(b, 1'b0);
        i2c_stop;
        chk("R9 current address read", b, 8'h77);
    endtask

    initial begin
        repeat (3000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        gap(5);
        rst = 1'b0;
        gap(5);
        t_reset;
        t_match;
        t_byte_write;
        t_busy;
        t_page;
        t_wp;
        t_low;
        t_restart;
        t_roll_and_current;
        gap(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule